// File: doc/BRIEF.md
# Memory-Access CRC16 Sequencer

This block keeps the 16-bit cyclic redundancy check that guards the command, address and data bytes of a serial memory-access transaction. The protocol engine around it hands over each byte together with one strobe that says what the byte is: a command, the low address byte, the high address byte, or a data byte. The block folds that byte into its CRC register, least-significant bit first, using the generator x^16 + x^15 + x^2 + 1.

A mode input chooses between read and write transactions, and a 16-bit input carries the current memory address. During a read, a check value is due each time the last byte of an 8-byte page has been folded in, and the next page starts again from a cleared register. During a write, a check value is due after every data byte. Each later write byte begins from the incremented address, which is loaded into the register as it is, without being shifted. The value handed out is always the bitwise inverse of the register, and it is marked by a one-cycle valid pulse.

Top module: `crc16_seq`

## Requirements
- R1: Each accepted byte is folded into the register LSB first, one bit at a time. For each bit the register shifts right, and it is XORed with 0xA001 whenever the old bit 0 differs from the data bit. A read that folds in the ASCII bytes "123456789" from a cleared register therefore yields a register value of 0xBB3D.
- R2: `crc_out` is always the bitwise complement of the register.
- R3: A command strobe clears the register and then folds in the command byte, whatever earlier state the register held.
- R4: In read mode (`mode_wr`=0), the command byte, both address bytes and then each data byte all accumulate into one register. The pass continues through the data byte accepted while `addr[2:0]`=3'b111.
- R5: No valid pulse follows a command or address strobe, or a read data byte accepted while `addr[2:0]` is not 3'b111.
- R6: After a read page end, the next read data byte is folded into a cleared register, so each later page's CRC covers only that page's data bytes.
- R7: In write mode (`mode_wr`=1), the first data byte after a command is folded into the register that holds the command and address. A valid pulse follows every write data byte.
- R8: Every later write data byte is folded into a register that was first loaded directly with `addr` (low byte in bits 7:0, high byte in bits 15:8).
- R9: `crc_vld` is high for exactly the one cycle after the emitting data strobe. In a cycle with no strobe the register, and so `crc_out`, keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the register and the pulse |
| mode_wr | input | 1 | 1 = write transaction, 0 = read transaction |
| byte_in | input | 8 | Byte accompanying the strobe |
| stb_cmd | input | 1 | Byte is the command byte |
| stb_alo | input | 1 | Byte is the address low byte |
| stb_ahi | input | 1 | Byte is the address high byte |
| stb_data | input | 1 | Byte is a data byte |
| addr | input | 16 | Current memory address of the data byte |
| crc_out | output | 16 | Complemented CRC register |
| crc_vld | output | 1 | One-cycle pulse marking a CRC due on the bus |

## Verification
The hardest situation to reach is the second read page. The clear there depends on state left behind by a page-end byte several strobes earlier, so an error shows only when a whole page has been walked through afterwards. The bench starts a read at address offset 2 so that the standard nine-character check string ends exactly on a page boundary. It then carries on across the following eight addresses and compares the result with a model started from zero. The write-continuation seeding is reached in a similar way, by strobing a second data byte without a new command.

// File: rtl/crc16_seq.sv
module crc16_seq #(
  parameter int          PAGE_BITS = 3,
  parameter logic [15:0] POLY_REV  = 16'hA001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [7:0]  byte_in,
  input  logic        stb_cmd,
  input  logic        stb_alo,
  input  logic        stb_ahi,
  input  logic        stb_data,
  input  logic [15:0] addr,
  output logic [15:0] crc_out,
  output logic        crc_vld
);

  function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY_REV;
      else             r = r >> 1;
    end
    return r;
  endfunction

  logic [15:0] crc_q;
  logic        restart_q;
  logic        vld_q;
  logic [15:0] base;

  wire any_stb  = stb_cmd | stb_alo | stb_ahi | stb_data;
  wire page_end = &addr[PAGE_BITS-1:0];
  wire emit     = stb_data & (mode_wr | page_end);

  always_comb begin
    base = crc_q;
    if (stb_cmd)                    base = '0;
    else if (stb_data && restart_q) base = mode_wr ? addr : '0;
  end

  wire [15:0] nxt = fold(base, byte_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q     <= '0;
      restart_q <= 1'b0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= emit;
      if (any_stb)       crc_q     <= nxt;
      if (stb_cmd)       restart_q <= 1'b0;
      else if (stb_data) restart_q <= emit;
    end
  end

  assign crc_out = ~crc_q;
  assign crc_vld = vld_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_cmd, stb_alo, stb_ahi, stb_data}));
  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_cmd || stb_alo || stb_ahi) |=> !crc_vld); // R5
  AST_RD_MID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_data && !mode_wr && addr[2:0] != 3'b111) |=> !crc_vld); // R5
  AST_RD_PAGE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_data && !mode_wr && addr[2:0] == 3'b111) |=> crc_vld); // R4
  AST_WR_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_data && mode_wr) |=> crc_vld); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_cmd || stb_alo || stb_ahi || stb_data) |=> ($stable(crc_out) && !crc_vld)); // R9

endmodule

// File: tb/crc16_seq_bench.sv
`timescale 1ns/1ps
module crc16_seq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_wr = 0;
  logic [7:0]  byte_in = 0;
  logic        stb_cmd = 0, stb_alo = 0, stb_ahi = 0, stb_data = 0;
  logic [15:0] addr = 0;
  logic [15:0] crc_out;
  logic        crc_vld;

  int n_chk = 0, n_fail = 0;
  logic done = 0;

  crc16_seq u_crc16_seq (.clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .byte_in(byte_in),
    .stb_cmd(stb_cmd), .stb_alo(stb_alo), .stb_ahi(stb_ahi), .stb_data(stb_data),
    .addr(addr), .crc_out(crc_out), .crc_vld(crc_vld));

  always #2 clk = ~clk;

  function automatic logic [15:0] m_fold(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 cmd, 1 alo, 2 ahi, 3 data; returns crc_vld seen after the edge
  task automatic send(input int kind, input logic [7:0] b, input logic [15:0] a, output logic v);
    @(negedge clk);
    byte_in = b; addr = a;
    stb_cmd = (kind == 0); stb_alo = (kind == 1); stb_ahi = (kind == 2); stb_data = (kind == 3);
    @(posedge clk); #1;
    v = crc_vld;
    stb_cmd = 0; stb_alo = 0; stb_ahi = 0; stb_data = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check(crc_out == 16'hFFFF, "R2 reset out", crc_out, 16'hFFFF);
    check(crc_vld == 0, "R9 reset vld", {15'b0, crc_vld}, 16'h0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_read_first_page();
    logic v; logic [15:0] m = 0; string s = "123456789";
    mode_wr = 0;
    send(0, s[0], 16'h0000, v); m = m_fold(16'h0, s[0]);
    check(v == 0, "R5 cmd quiet", {15'b0, v}, 16'h0);
    check(crc_out == ~m, "R3 cmd fold", crc_out, ~m);
    send(1, s[1], 16'h0000, v);
    check(v == 0, "R5 alo quiet", {15'b0, v}, 16'h0);
    send(2, s[2], 16'h0000, v);
    for (int i = 3; i < 9; i++) begin
      send(3, s[i], 16'h0002 + 16'(i - 3), v);
      if (i < 8) check(v == 0, "R5 mid-page quiet", {15'b0, v}, 16'h0);
    end
    check(v == 1, "R4 page end pulse", {15'b0, v}, 16'h1);
    check(crc_out == ~16'hBB3D, "R1 R2 check string", crc_out, ~16'hBB3D);
    @(posedge clk); #1;
    check(crc_vld == 0, "R9 single pulse", {15'b0, crc_vld}, 16'h0);
    check(crc_out == ~16'hBB3D, "R9 hold", crc_out, ~16'hBB3D);
  endtask

  task automatic t_read_next_page();
    logic v; logic [15:0] m = 0; int pulses = 0;
    for (int i = 0; i < 8; i++) begin
      send(3, 8'(8'hA0 + i * 7), 16'h0008 + 16'(i), v);
      m = m_fold(m, 8'(8'hA0 + i * 7));
      if (v) pulses++;
    end
    check(pulses == 1 && v == 1, "R6 one pulse at page end", 16'(pulses), 16'h1);
    check(crc_out == ~m, "R6 cleared page CRC", crc_out, ~m);
  endtask

  task automatic t_write();
    logic v; logic [15:0] m;
    mode_wr = 1;
    send(3, 8'h11, 16'h0003, v);
    send(0, 8'h0F, 16'h0123, v); m = m_fold(16'h0, 8'h0F);
    check(crc_out == ~m, "R3 cmd clears", crc_out, ~m);
    send(1, 8'h23, 16'h0123, v); m = m_fold(m, 8'h23);
    send(2, 8'h01, 16'h0123, v); m = m_fold(m, 8'h01);
    check(v == 0, "R5 ahi quiet", {15'b0, v}, 16'h0);
    send(3, 8'h5A, 16'h0123, v); m = m_fold(m, 8'h5A);
    check(v == 1, "R7 write pulse", {15'b0, v}, 16'h1);
    check(crc_out == ~m, "R7 first write CRC", crc_out, ~m);
    send(3, 8'hC3, 16'h0124, v); m = m_fold(16'h0124, 8'hC3);
    check(v == 1, "R7 continuation pulse", {15'b0, v}, 16'h1);
    check(crc_out == ~m, "R8 seeded continuation", crc_out, ~m);
    send(3, 8'h7E, 16'hBEEF, v); m = m_fold(16'hBEEF, 8'h7E);
    check(crc_out == ~m, "R8 seed byte order", crc_out, ~m);
    repeat (3) @(posedge clk);
    #1;
    check(crc_out == ~m && crc_vld == 0, "R9 idle hold", crc_out, ~m);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_first_page();
    t_read_next_page();
    t_write();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule